// File: doc/BRIEF.md
# UART Receiver Standby and Wake Control

This block manages the standby (mute) state of a UART receiver. Software raises a one-cycle request to enter standby. While in standby the receiver drops the characters and idle periods it sees, and the block takes itself out of standby when the line shows the selected wake condition. Software never clears standby directly. Two wake modes exist. In idle-line mode an idle line between messages ends standby. In address-mark mode a received character whose most significant data bit is 1 ends standby.

The receiver datapath sends two single-cycle pulses: one when a line idle is detected, and one when a character is complete, together with that character's top data bit. From these the block keeps a receive-data-full flag and an idle flag, each with its own clear pulse. It also raises an idle interrupt request when the idle flag is set and the interrupt is enabled. An idle counts as one full character time of logic 1 after a stop bit, and the datapath measures it. Line events are only accepted while the receiver is enabled and loop mode is off, because in loop mode the external line is not used.

Top module: `uart_rx_wakeup`

## Requirements
- R1: After reset `rwu_o`, `flag_gate_o`, `rdf_o`, `idle_flag_o` and `idle_irq_o` are all 0.
- R2: A `rwu_set_i` pulse makes `rwu_o` and `flag_gate_o` 1 from the next cycle on.
- R3: When `wake_sel_i` = 0 (idle-line mode), an accepted idle pulse during standby clears `rwu_o` in the next cycle and does not set `idle_flag_o`.
- R4: When `wake_sel_i` = 0, a character pulse during standby does not clear `rwu_o` and does not set `rdf_o`, whatever its top bit is.
- R5: When `wake_sel_i` = 1 (address-mark mode), a character pulse with `char_msb_i` = 1 during standby clears `rwu_o` and sets `rdf_o` in the next cycle.
- R6: When `wake_sel_i` = 1, during standby a character with `char_msb_i` = 0 sets no flag and keeps standby, and an idle pulse sets no flag and keeps standby.
- R7: Outside standby, an accepted character pulse sets `rdf_o` and an accepted idle pulse sets `idle_flag_o` in the next cycle.
- R8: While `rx_en_i` = 0 or `loop_mode_i` = 1, idle and character pulses set no flag and cause no wake.
- R9: `idle_irq_o` is 1 exactly when `idle_flag_o` = 1 and `idle_ie_i` = 1, and it follows `idle_ie_i` in the same cycle.
- R10: `rdf_clr_i` and `idle_clr_i` clear their flag in the next cycle. When a set and a clear of the same flag arrive in one cycle, the set wins.
- R11: When `rwu_set_i` and a wake condition arrive in the same cycle, `rwu_o` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receiver enable |
| loop_mode_i | input | 1 | Loop mode; the external line is ignored |
| wake_sel_i | input | 1 | Wake mode: 0 idle-line, 1 address-mark |
| rwu_set_i | input | 1 | Software pulse to enter standby |
| idle_ie_i | input | 1 | Idle interrupt enable |
| idle_det_i | input | 1 | Line idle detected (pulse) |
| char_done_i | input | 1 | Character received (pulse) |
| char_msb_i | input | 1 | Top data bit of the received character |
| rdf_clr_i | input | 1 | Clear the data-full flag (pulse) |
| idle_clr_i | input | 1 | Clear the idle flag (pulse) |
| rwu_o | output | 1 | Standby status |
| flag_gate_o | output | 1 | Receive flags are suppressed |
| rdf_o | output | 1 | Receive data full flag |
| idle_flag_o | output | 1 | Idle flag |
| idle_irq_o | output | 1 | Idle interrupt request |

## Verification
The conflict this block has to resolve is a software request to enter standby that lands in the same cycle as a wake condition. A related collision is an idle pulse that arrives in the same cycle the standby request is written. The bench drives `rwu_set_i` and `idle_det_i` together on one edge, both while the receiver is already in standby and while it is awake. It then requires `rwu_o` to be 1 afterwards in both cases. In the awake case it also requires `idle_flag_o` to be set, because suppression only starts in the cycle after the request.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;
  typedef enum logic {
    WAKE_IDLE = 1'b0,
    WAKE_ADDR = 1'b1
  } wake_mode_e;

  localparam int unsigned NUM_FLAGS = 2;
  localparam int unsigned FLAG_RDF  = 0;
  localparam int unsigned FLAG_IDLE = 1;
endpackage

// File: rtl/uart_wake_detect.sv
module uart_wake_detect
  import uart_wake_pkg::*;
(
  input  logic       rx_en_i,
  input  logic       loop_mode_i,
  input  wake_mode_e mode_i,
  input  logic       rwu_i,
  input  logic       idle_det_i,
  input  logic       char_done_i,
  input  logic       char_msb_i,
  output logic       wake_o,
  output logic       char_accept_o,
  output logic       idle_accept_o
);
  logic line_live, idle_ev, char_ev, addr_mark;

  // external line only counts when enabled and not looped back
  assign line_live = rx_en_i & ~loop_mode_i;
  assign idle_ev   = line_live & idle_det_i;
  assign char_ev   = line_live & char_done_i;
  assign addr_mark = (mode_i == WAKE_ADDR) & char_ev & char_msb_i;

  always_comb begin
    wake_o = 1'b0;
    if (rwu_i) begin
      unique case (mode_i)
        WAKE_IDLE: wake_o = idle_ev;
        WAKE_ADDR: wake_o = addr_mark;
        default:   wake_o = 1'b0;
      endcase
    end
  end

  // waking address character is delivered; waking idle is not flagged
  assign char_accept_o = char_ev & (~rwu_i | addr_mark);
  assign idle_accept_o = idle_ev & ~rwu_i;
endmodule

// File: rtl/uart_rwu_state.sv
module uart_rwu_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wake_i,
  output logic rwu_o
);
  logic rwu_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rwu_q <= 1'b0;
    else if (set_i)  rwu_q <= 1'b1;   // software request beats wake
    else if (wake_i) rwu_q <= 1'b0;
  end

  assign rwu_o = rwu_q;

  p_enter_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> rwu_q);
  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && wake_i) |=> rwu_q);
  p_wake_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && !set_i) |=> !rwu_q);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rwu_q && !wake_i) |=> rwu_q);
endmodule

// File: rtl/uart_sticky_flag.sv
module uart_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= 1'b0;
    else if (set_i)  q_q <= 1'b1;
    else if (clr_i)  q_q <= 1'b0;
  end

  assign q_o = q_q;

  p_set_beats_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_q);
  p_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_q);
endmodule

// File: rtl/uart_rx_wakeup.sv
module uart_rx_wakeup
  import uart_wake_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_en_i,
  input  logic loop_mode_i,
  input  logic wake_sel_i,
  input  logic rwu_set_i,
  input  logic idle_ie_i,
  input  logic idle_det_i,
  input  logic char_done_i,
  input  logic char_msb_i,
  input  logic rdf_clr_i,
  input  logic idle_clr_i,
  output logic rwu_o,
  output logic flag_gate_o,
  output logic rdf_o,
  output logic idle_flag_o,
  output logic idle_irq_o
);
  wake_mode_e           mode;
  logic                 rwu_q, wake, char_acc, idle_acc;
  logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;

  assign mode = wake_mode_e'(wake_sel_i);

  uart_wake_detect u_detect (
    .rx_en_i       (rx_en_i),
    .loop_mode_i   (loop_mode_i),
    .mode_i        (mode),
    .rwu_i         (rwu_q),
    .idle_det_i    (idle_det_i),
    .char_done_i   (char_done_i),
    .char_msb_i    (char_msb_i),
    .wake_o        (wake),
    .char_accept_o (char_acc),
    .idle_accept_o (idle_acc)
  );

  uart_rwu_state u_rwu (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (rwu_set_i),
    .wake_i (wake),
    .rwu_o  (rwu_q)
  );

  assign flag_set[FLAG_RDF]  = char_acc;
  assign flag_set[FLAG_IDLE] = idle_acc;
  assign flag_clr[FLAG_RDF]  = rdf_clr_i;
  assign flag_clr[FLAG_IDLE] = idle_clr_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    uart_sticky_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flag_set[g]),
      .clr_i  (flag_clr[g]),
      .q_o    (flag_q[g])
    );
  end

  assign rwu_o       = rwu_q;
  assign flag_gate_o = rwu_q;
  assign rdf_o       = flag_q[FLAG_RDF];
  assign idle_flag_o = flag_q[FLAG_IDLE];
  assign idle_irq_o  = flag_q[FLAG_IDLE] & idle_ie_i;

  p_idle_suppressed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rwu_q && !flag_q[FLAG_IDLE]) |=> !flag_q[FLAG_IDLE]);
  p_line_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!rx_en_i || loop_mode_i) && !rwu_set_i && rwu_q) |=> rwu_q);
  p_off_no_rdf_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!rx_en_i || loop_mode_i) && !flag_q[FLAG_RDF]) |=> !flag_q[FLAG_RDF]);
  p_irq_needs_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_irq_o |-> (flag_q[FLAG_IDLE] && idle_ie_i));
endmodule

// File: tb/tb_uart_rx_wakeup.sv
module tb_uart_rx_wakeup;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni, rx_en_i, loop_mode_i, wake_sel_i, rwu_set_i, idle_ie_i;
  logic idle_det_i, char_done_i, char_msb_i, rdf_clr_i, idle_clr_i;
  logic rwu_o, flag_gate_o, rdf_o, idle_flag_o, idle_irq_o;
  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_wakeup dut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_en_i(rx_en_i), .loop_mode_i(loop_mode_i),
    .wake_sel_i(wake_sel_i), .rwu_set_i(rwu_set_i), .idle_ie_i(idle_ie_i),
    .idle_det_i(idle_det_i), .char_done_i(char_done_i), .char_msb_i(char_msb_i),
    .rdf_clr_i(rdf_clr_i), .idle_clr_i(idle_clr_i), .rwu_o(rwu_o),
    .flag_gate_o(flag_gate_o), .rdf_o(rdf_o), .idle_flag_o(idle_flag_o),
    .idle_irq_o(idle_irq_o)
  );

  task automatic check(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // one edge: inputs driven after negedge, sampled at the following negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    rwu_set_i = 0; idle_det_i = 0; char_done_i = 0;
    rdf_clr_i = 0; idle_clr_i = 0;
  endtask

  task automatic clear_flags();
    rdf_clr_i = 1; idle_clr_i = 1;
    step();
  endtask

  task automatic enter_standby();
    rwu_set_i = 1;
    step();
  endtask

  task automatic t_reset();
    check("R1", "rwu", rwu_o, 1'b0);
    check("R1", "gate", flag_gate_o, 1'b0);
    check("R1", "rdf", rdf_o, 1'b0);
    check("R1", "idle", idle_flag_o, 1'b0);
    check("R1", "irq", idle_irq_o, 1'b0);
  endtask

  task automatic t_enter();
    rx_en_i = 1; wake_sel_i = 0;
    enter_standby();
    check("R2", "rwu after set", rwu_o, 1'b1);
    check("R2", "gate after set", flag_gate_o, 1'b1);
  endtask

  task automatic t_idle_mode();
    char_done_i = 1; char_msb_i = 1;
    step();
    check("R4", "rwu after msb1 char", rwu_o, 1'b1);
    check("R4", "rdf after msb1 char", rdf_o, 1'b0);
    char_done_i = 1; char_msb_i = 0;
    step();
    check("R4", "rwu after msb0 char", rwu_o, 1'b1);
    check("R4", "rdf after msb0 char", rdf_o, 1'b0);
    idle_det_i = 1;
    step();
    check("R3", "rwu after idle wake", rwu_o, 1'b0);
    check("R3", "gate after idle wake", flag_gate_o, 1'b0);
    check("R3", "idle flag from waking idle", idle_flag_o, 1'b0);
  endtask

  task automatic t_normal();
    char_done_i = 1; char_msb_i = 0;
    step();
    check("R7", "rdf set", rdf_o, 1'b1);
    idle_det_i = 1;
    step();
    check("R7", "idle set", idle_flag_o, 1'b1);
    rdf_clr_i = 1;
    step();
    check("R10", "rdf cleared", rdf_o, 1'b0);
    check("R10", "idle kept", idle_flag_o, 1'b1);
    idle_clr_i = 1;
    step();
    check("R10", "idle cleared", idle_flag_o, 1'b0);
    char_done_i = 1; rdf_clr_i = 1;
    step();
    check("R10", "rdf set beats clear", rdf_o, 1'b1);
    idle_det_i = 1; idle_clr_i = 1;
    step();
    check("R10", "idle set beats clear", idle_flag_o, 1'b1);
    clear_flags();
  endtask

  task automatic t_addr_mode();
    wake_sel_i = 1;
    enter_standby();
    idle_det_i = 1;
    step();
    check("R6", "rwu after idle", rwu_o, 1'b1);
    check("R6", "idle flag suppressed", idle_flag_o, 1'b0);
    char_done_i = 1; char_msb_i = 0;
    step();
    check("R6", "rwu after msb0 char", rwu_o, 1'b1);
    check("R6", "rdf suppressed", rdf_o, 1'b0);
    char_done_i = 1; char_msb_i = 1;
    step();
    check("R5", "rwu after address mark", rwu_o, 1'b0);
    check("R5", "rdf from address mark", rdf_o, 1'b1);
    clear_flags();
    wake_sel_i = 0;
  endtask

  task automatic t_irq();
    idle_ie_i = 0; idle_det_i = 1;
    step();
    check("R9", "flag set", idle_flag_o, 1'b1);
    check("R9", "irq masked", idle_irq_o, 1'b0);
    idle_ie_i = 1;
    #1;
    check("R9", "irq enabled", idle_irq_o, 1'b1);
    idle_clr_i = 1;
    step();
    check("R9", "irq after clear", idle_irq_o, 1'b0);
    idle_ie_i = 0;
  endtask

  task automatic t_off();
    wake_sel_i = 0;
    enter_standby();
    rx_en_i = 0; idle_det_i = 1;
    step();
    check("R8", "no wake when disabled", rwu_o, 1'b1);
    rx_en_i = 1; loop_mode_i = 1; idle_det_i = 1;
    step();
    check("R8", "no wake in loop mode", rwu_o, 1'b1);
    wake_sel_i = 1; char_done_i = 1; char_msb_i = 1;
    step();
    check("R8", "no address wake in loop mode", rwu_o, 1'b1);
    check("R8", "no rdf in loop mode", rdf_o, 1'b0);
    loop_mode_i = 0; wake_sel_i = 0; idle_det_i = 1;
    step();
    check("R8", "wake once live", rwu_o, 1'b0);
    rx_en_i = 0; char_done_i = 1;
    step();
    check("R8", "no rdf when disabled", rdf_o, 1'b0);
    rx_en_i = 1; loop_mode_i = 1; idle_det_i = 1;
    step();
    check("R8", "no idle flag in loop mode", idle_flag_o, 1'b0);
    loop_mode_i = 0;
  endtask

  task automatic t_same_cycle();
    wake_sel_i = 0;
    enter_standby();
    rwu_set_i = 1; idle_det_i = 1;
    step();
    check("R11", "set and wake in standby", rwu_o, 1'b1);
    idle_det_i = 1;
    step();
    check("R3", "wake before next test", rwu_o, 1'b0);
    clear_flags();
    rwu_set_i = 1; idle_det_i = 1;
    step();
    check("R11", "set with idle while awake", rwu_o, 1'b1);
    check("R11", "idle flag of same cycle", idle_flag_o, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; rx_en_i = 0; loop_mode_i = 0; wake_sel_i = 0; rwu_set_i = 0;
    idle_ie_i = 0; idle_det_i = 0; char_done_i = 0; char_msb_i = 0;
    rdf_clr_i = 0; idle_clr_i = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_enter();
    t_idle_mode();
    t_normal();
    t_addr_mode();
    t_irq();
    t_off();
    t_same_cycle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule